// File: doc/BRIEF.md
# Packed-Lane Saturating Adder

This block adds or subtracts two 64-bit words that are treated as a row of independent integer lanes. The lane width is chosen at run time and can be 8, 16 or 32 bits. No carry or borrow crosses from one lane into the next. Each lane then takes the wrapped result, or clamps it by itself under a signed or unsigned saturation rule. The result and a per-byte clamp flag vector are held in one output register.

Operands come in through a valid/ready stream and the result leaves through another. An input beat is accepted on a rising edge when `in_valid` and `in_ready` are both high. The result is presented with `out_valid` on the next cycle. The downstream side applies back-pressure by holding `out_ready` low. While it does, the registered result, the flags and `out_valid` stay unchanged, and `in_ready` is low. A beat can be accepted in the same cycle that the waiting result is taken.

The operation pins (`sub`, `lane_sel`, `sat_en`, `is_signed`) belong to the input beat and are sampled with it.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_sel` encodes the lane width: 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. Lane k occupies bits [k*w +: w]. No carry or borrow passes from one lane into another.
- R2: With `sub`=0 each lane produces a+b. With `sat_en`=0 the lane keeps the low w bits of that sum.
- R3: With `sub`=1 each lane produces a-b. With `sat_en`=0 the lane keeps the low w bits of that difference.
- R4: With `sat_en`=0 no lane clamps, and every bit of `sat_flags` is 0.
- R5: With `sat_en`=1 and `is_signed`=1, the lanes are two's-complement. A result above the lane maximum becomes 2^(w-1)-1, and a result below the lane minimum becomes -2^(w-1).
- R6: With `sat_en`=1 and `is_signed`=0, the lanes are unsigned. A sum above 2^w-1 becomes all ones, and a difference below zero becomes zero.
- R7: `sat_flags` bit i belongs to byte i, which is bits [8i +: 8]. The bit is 1 exactly when the lane that contains byte i clamped. The same value therefore appears on every byte of a 16-bit or 32-bit lane.
- R8: An accepted beat sets `out_valid` on the next rising edge, with that beat's result and flags.
- R9: While `out_valid`=1 and `out_ready`=0, the values of `result`, `sat_flags` and `out_valid` hold, and `in_ready` is 0.
- R10: After reset, `out_valid`, `result` and `sat_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| a | input | 64 | First packed operand |
| b | input | 64 | Second packed operand |
| sub | input | 1 | 1 = subtract b from a, 0 = add |
| lane_sel | input | 2 | Lane width code (see R1) |
| sat_en | input | 1 | 1 = saturate, 0 = wrap |
| is_signed | input | 1 | Saturation uses signed lanes when 1 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result beat |
| result | output | 64 | Packed lane results |
| sat_flags | output | 8 | Per-byte clamp flags |

## Verification
The assertions assume that the operation pins are valid only when `in_valid` is high. They also assume that the upstream side does not rely on a beat being taken while `in_ready` is low. The bench changes inputs only on falling edges and holds a beat until it sees `in_ready`.

Its random stimulus covers all four lane codes and all mode combinations. The directed cases push each lane width to its exact overflow and underflow boundaries. The back-pressure sequence offers a second beat while the output is stalled, so that the bench can confirm the beat is held back and not taken.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    LANE_B8   = 2'd0,
    LANE_B16  = 2'd1,
    LANE_B32  = 2'd2,
    LANE_B32X = 2'd3
  } lane_e;

  // Low byte-index bits that are shared by the bytes of one lane
  function automatic int unsigned lane_mask(input lane_e lw);
    case (lw)
      LANE_B8:  return 0;
      LANE_B16: return 1;
      default:  return 3;
    endcase
  endfunction

  // Byte idx begins a lane: the carry chain is cut here
  function automatic logic lane_start(input int unsigned idx, input lane_e lw);
    return (idx & lane_mask(lw)) == 0;
  endfunction

  // Index of the most significant byte of the lane holding byte idx
  function automatic int unsigned lane_top(input int unsigned idx, input lane_e lw);
    return idx | lane_mask(lw);
  endfunction
endpackage

// File: rtl/simd_byte_add.sv
module simd_byte_add (
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       cin,
  output logic [7:0] sum,
  output logic       cout,
  output logic       sovf
);
  logic [7:0] low;
  logic [1:0] high;

  // Split at the MSB so that the carry into the sign bit is visible
  assign low  = {1'b0, a[6:0]} + {1'b0, b[6:0]} + {7'd0, cin};
  assign high = {1'b0, a[7]} + {1'b0, b[7]} + {1'b0, low[7]};
  assign sum  = {high[0], low[6:0]};
  assign cout = high[1];
  assign sovf = high[1] ^ low[7];
endmodule

// File: rtl/simd_byte_sat.sv
module simd_byte_sat (
  input  logic [7:0] raw,
  input  logic       is_top,
  input  logic       top_cout,
  input  logic       top_sovf,
  input  logic       top_amsb,
  input  logic       sub,
  input  logic       sat_en,
  input  logic       is_signed,
  output logic [7:0] res,
  output logic       hit
);
  logic [7:0] clamp;

  always_comb begin
    if (is_signed) begin
      hit = sat_en & top_sovf;
      // Overflow direction follows the sign of the first operand
      if (top_amsb) clamp = is_top ? 8'h80 : 8'h00;
      else          clamp = is_top ? 8'h7F : 8'hFF;
    end else begin
      hit   = sat_en & (sub ? ~top_cout : top_cout);
      clamp = sub ? 8'h00 : 8'hFF;
    end
    res = hit ? clamp : raw;
  end
endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [1:0]        lane_sel,
  input  logic              sat_en,
  input  logic              is_signed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W/8-1:0] sat_flags
);
  import simd_pkg::*;

  localparam int unsigned NB = DATA_W / 8;
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

  lane_e              lw;
  logic [NB-1:0]      cin_v, cout_v, sovf_v, amsb_v, hit_v;
  logic [DATA_W-1:0]  raw_v, res_v;
  logic               accept;

  assign lw = lane_e'(lane_sel);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [IW-1:0] ti;
    logic [7:0]    b_eff;

    assign b_eff     = b[8*i +: 8] ^ {8{sub}};
    assign amsb_v[i] = a[8*i + 7];
    assign ti        = IW'(lane_top(i, lw));

    if (i == 0) begin : g_first
      assign cin_v[i] = sub;
    end else begin : g_chain
      assign cin_v[i] = lane_start(i, lw) ? sub : cout_v[i-1];
    end

    simd_byte_add u_add (
      .a    (a[8*i +: 8]),
      .b    (b_eff),
      .cin  (cin_v[i]),
      .sum  (raw_v[8*i +: 8]),
      .cout (cout_v[i]),
      .sovf (sovf_v[i])
    );

    simd_byte_sat u_sat (
      .raw       (raw_v[8*i +: 8]),
      .is_top    (ti == IW'(i)),
      .top_cout  (cout_v[ti]),
      .top_sovf  (sovf_v[ti]),
      .top_amsb  (amsb_v[ti]),
      .sub       (sub),
      .sat_en    (sat_en),
      .is_signed (is_signed),
      .res       (res_v[8*i +: 8]),
      .hit       (hit_v[i])
    );
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flags <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= res_v;
      sat_flags <= hit_v;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        lane_sel,
  input logic              sat_en,
  input logic              is_signed,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W/8-1:0] sat_flags
);
  localparam int unsigned NB = DATA_W / 8;

  function automatic logic pairs_ok(input logic [NB-1:0] f);
    for (int k = 0; k + 1 < NB; k += 2)
      if (f[k] != f[k+1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic uns_ok(input logic [DATA_W-1:0] r, input logic [NB-1:0] f);
    for (int k = 0; k < NB; k++)
      if (f[k] && r[8*k +: 8] != 8'hFF && r[8*k +: 8] != 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(sat_flags));

  a_r9_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r4_modulo_clean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !sat_en |=> sat_flags == '0);

  a_r7_flag_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && lane_sel == 2'd1 |=> pairs_ok(sat_flags));

  a_r6_unsigned_value: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && sat_en && !is_signed |=> uns_ok(result, sat_flags));
endmodule

bind simd_sat_adder simd_sat_adder_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [63:0] a = '0, b = '0, result;
  logic        sub = 1'b0, sat_en = 1'b0, is_signed = 1'b0;
  logic [1:0]  lane_sel = 2'd0;
  logic [7:0]  sat_flags;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_adder u_dut (.*);

  function automatic logic [71:0] model(input logic [63:0] x, y, input logic s,
                                        input logic [1:0] ls, input logic sat, sgn);
    int w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    logic [63:0] r = '0;
    logic [7:0]  f = '0;
    for (int l = 0; l < 64 / w; l++) begin
      longint ua = longint'(x >> (l * w)) & mask;
      longint ub = longint'(y >> (l * w)) & mask;
      longint v, lo, hi;
      bit hit = 0;
      if (sat && sgn) begin
        if (ua >= half) ua = ua - (mask + 1);
        if (ub >= half) ub = ub - (mask + 1);
        lo = -half; hi = half - 1;
      end else begin
        lo = 0; hi = mask;
      end
      v = s ? ua - ub : ua + ub;
      if (sat && v > hi) begin v = hi; hit = 1; end
      if (sat && v < lo) begin v = lo; hit = 1; end
      r = r | ((64'(v) & 64'(mask)) << (l * w));
      if (hit) f = f | (8'(((1 << (w / 8)) - 1)) << (l * w / 8));
    end
    return {f, r};
  endfunction

  task automatic check(input string req, input logic [71:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got flags=%h res=%h expected flags=%h res=%h",
               req, got[71:64], got[63:0], exp[71:64], exp[63:0]);
    end
  endtask

  task automatic apply(input string req, input logic [63:0] x, y, input logic s,
                       input logic [1:0] ls, input logic sat, sgn);
    @(negedge clk);
    a = x; b = y; sub = s; lane_sel = ls; sat_en = sat; is_signed = sgn;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {71'd0, out_valid}, 72'd1);
    check(req, {sat_flags, result}, model(x, y, s, ls, sat, sgn));
  endtask

  initial begin
    logic [71:0] ex, ey;
    void'($urandom(32'h5EED1234));
    #(CLK_PERIOD * 2 + 2);
    check("R10 reset", {sat_flags, result, 7'd0, out_valid}, 80'd0);
    rst_n = 1'b1;

    // R2 R4 modulo add wraps per lane, carry cut at byte boundary (R1)
    apply("R2", 64'h00000000_000000FF, 64'h00000000_00000001, 0, 2'd0, 0, 0);
    // R1 carry crosses a byte inside a 16-bit lane but stops at the lane edge
    apply("R1", 64'h00000000_FFFF00FF, 64'h00000000_00010001, 0, 2'd1, 0, 0);
    // R3 modulo subtract with a 32-bit lane borrow cut
    apply("R3", 64'h00000000_00000000, 64'h00000000_00000001, 1, 2'd2, 0, 0);
    // R1 code 3 acts as 32-bit
    apply("R1 code3", 64'hFFFFFFFF_FFFFFFFF, 64'h00000001_00000001, 0, 2'd3, 0, 0);
    // R5 signed clamps at both ends, R7 flags per byte
    apply("R5 pos8", 64'h7F7F7F7F_7F7F7F7F, 64'h01000100_01000100, 0, 2'd0, 1, 1);
    apply("R5 neg16", 64'h80000000_80000000, 64'h00010000_00010000, 1, 2'd1, 1, 1);
    apply("R5 32", 64'h7FFFFFFF_80000000, 64'h00000001_00000001, 0, 2'd2, 1, 1);
    // R6 unsigned clamps
    apply("R6 add", 64'hFFFF0000_FFFE0001, 64'h00010000_00010001, 0, 2'd1, 1, 0);
    apply("R6 sub", 64'h00000000_00000005, 64'h00000001_00000006, 1, 2'd2, 1, 0);
    // R7 replication and R4 no flags when wrapping the same overflow
    apply("R7", 64'hFFFFFFFF_00000000, 64'h00000001_00000000, 0, 2'd2, 1, 0);
    apply("R4", 64'hFFFFFFFF_7FFFFFFF, 64'h00000001_00000001, 0, 2'd2, 0, 1);

    // R9 back-pressure: result holds, second beat is refused
    ex = model(64'h01020304_05060708, 64'h10101010_10101010, 0, 2'd0, 0, 0);
    ey = model(64'hF0F0F0F0_F0F0F0F0, 64'h20202020_20202020, 0, 2'd0, 1, 0);
    @(negedge clk);
    a = 64'h01020304_05060708; b = 64'h10101010_10101010;
    sub = 0; lane_sel = 2'd0; sat_en = 0; is_signed = 0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    a = 64'hF0F0F0F0_F0F0F0F0; b = 64'h20202020_20202020; sat_en = 1;
    check("R9 ready low", {70'd0, in_ready, out_valid}, 72'd1);
    check("R8 first", {sat_flags, result}, ex);
    @(negedge clk);
    check("R9 held", {sat_flags, result}, ex);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next beat", {sat_flags, result}, ey);
    @(negedge clk);
    check("R8 drained", {71'd0, out_valid}, 72'd0);

    // random mix across all modes
    for (int k = 0; k < 400; k++) begin
      logic [63:0] rx = {$urandom, $urandom};
      logic [63:0] ry = {$urandom, $urandom};
      logic [3:0]  m = 4'($urandom);
      logic [1:0]  rl = 2'($urandom);
      apply("R1-mix R2/R3/R5/R6/R7", rx, ry, m[0], rl, m[1], m[2]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule